// File: doc/BRIEF.md
# Configurable Pin Input Glitch Filter

This block conditions one asynchronous digital input pin before core logic uses it. A run-time mode field chooses one of three treatments. The pin can be passed straight through with no register in the path. It can be resynchronized to the system clock. It can also go through an agreement filter that accepts a new level only after a chosen number of consecutive samples, from two to five, all show that level. An optional inversion is applied to whichever result is selected.

The agreement filter does not sample on every clock. A select field picks one bit of an externally supplied strobe vector, and the filter takes a sample only in cycles where that bit is high. Slow strobes therefore stretch the rejection window without a wider counter. The strobe dividers and the configuration register live outside this block. A change of mode discards the filter's run history, so a new mode never inherits a partial run.

Top module: `pin_cond_filter`

## Requirements
- R1: While `rst_n` is low, with `mode_sel`=0 and `invert`=0, `pin_out` is 0 whatever `pin_raw` is. Reset clears the filter's held level, its run count and its sample history.
- R2: With `mode_sel`=0, `pin_out` takes a new `pin_raw` level two rising clock edges after the pin changes. The path is a two-flop synchronizer.
- R3: With `mode_sel`=1, `pin_out` follows `pin_raw` combinationally. No clock edge is needed.
- R4: With `mode_sel`=N for N in 2..5, `pin_out` changes only once N consecutive samples agree on the new level. The update happens on the sample that completes the run. Samples are taken from the synchronizer output. With the selected strobe held high, a clean pin transition reaches `pin_out` N+2 edges after the pin changes.
- R5: A sample that differs from the one before it restarts the run at one. A pin pulse that yields fewer than N agreeing samples leaves `pin_out` unchanged.
- R6: In filter modes, a sample is taken only in cycles where `strobe_vec[strobe_sel]` is 1. The other bits of `strobe_vec` have no effect.
- R7: When `invert`=1, `pin_out` is the complement of the level the selected mode would otherwise give. This applies to every mode.
- R8: `mode_sel` values 6 and 7 behave exactly as value 0.
- R9: A clock edge where `mode_sel` differs from its value at the previous edge clears the run history and takes no sample. A filter run then needs its full N samples after the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_raw | input | 1 | Asynchronous pin level |
| mode_sel | input | 3 | 0 sync, 1 direct, 2..5 agreement of that many samples, 6..7 as 0 |
| strobe_sel | input | 3 | Index of the sample strobe in `strobe_vec` |
| strobe_vec | input | 8 | Candidate sample-enable strobes |
| invert | input | 1 | Complement the conditioned level |
| pin_out | output | 1 | Conditioned pin level |

## Verification
The bench drives clean single transitions in each mode and measures the edge count until `pin_out` follows. This separates the direct path (0 edges), the synchronizer (2 edges) and each filter depth (N+2 edges). Pulses one sample shorter and exactly as long as the required run show that the filter rejects and accepts at the correct boundary. Pulsing only the selected strobe, while the unselected strobes stay high, shows that sampling is paced by the chosen bit alone. A mode switch in the middle of a run shows that the count restarts from zero.

// File: rtl/pcf_pkg.sv
package pcf_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    PCF_SYNC   = 3'd0,
    PCF_DIRECT = 3'd1,
    PCF_AGR2   = 3'd2,
    PCF_AGR3   = 3'd3,
    PCF_AGR4   = 3'd4,
    PCF_AGR5   = 3'd5,
    PCF_RSV6   = 3'd6,
    PCF_RSV7   = 3'd7
  } pcf_mode_e;

  localparam int RUN_MAX = 5;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);

  function automatic logic pcf_is_filter(input logic [MODE_W-1:0] m);
    return (m >= 3'd2) && (m <= 3'd5);
  endfunction

  // samples that must agree for an agreement mode
  function automatic logic [RUN_W-1:0] pcf_run_need(input logic [MODE_W-1:0] m);
    return RUN_W'(m);
  endfunction

  function automatic logic [RUN_W-1:0] pcf_run_inc(input logic [RUN_W-1:0] r);
    return (r >= RUN_W'(RUN_MAX)) ? RUN_W'(RUN_MAX) : r + 1'b1;
  endfunction
endpackage

// File: rtl/pcf_sync.sv
module pcf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int WARM_W = $clog2(STAGES + 1);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= '0;
        else        chain_q <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end
  endgenerate

  assign q = chain_q[STAGES-1];

  logic [WARM_W-1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                       warm_q <= '0;
    else if (warm_q < WARM_W'(STAGES)) warm_q <= warm_q + 1'b1;

  // R2
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == WARM_W'(STAGES)) |-> (q == $past(d, STAGES)));
endmodule

// File: rtl/pcf_agree.sv
module pcf_agree
  import pcf_pkg::*;
#(
  parameter int STROBE_CNT = 8,
  localparam int SEL_W = $clog2(STROBE_CNT)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  smp,
  input  logic [MODE_W-1:0]     mode_sel,
  input  logic [SEL_W-1:0]      strobe_sel,
  input  logic [STROBE_CNT-1:0] strobe_vec,
  output logic                  filt
);
  logic [MODE_W-1:0] mode_q;
  logic [RUN_W-1:0]  run_q, run_nx;
  logic              prev_q, prev_nx;
  logic              filt_q, filt_nx;
  logic              strobe_hit;
  logic              mode_chg;
  logic              smp_en;
  logic              smp_diff;
  logic              run_done;

  assign strobe_hit = strobe_vec[strobe_sel];
  assign mode_chg   = (mode_sel != mode_q);
  assign smp_en     = strobe_hit && pcf_is_filter(mode_sel) && !mode_chg;
  assign smp_diff   = (run_q == '0) || (smp != prev_q);

  always_comb begin
    run_nx  = run_q;
    prev_nx = prev_q;
    if (mode_chg) begin
      run_nx  = '0;
      prev_nx = 1'b0;
    end else if (smp_en) begin
      run_nx  = smp_diff ? RUN_W'(1) : pcf_run_inc(run_q);
      prev_nx = smp;
    end
  end

  assign run_done = smp_en && (run_nx >= pcf_run_need(mode_sel));
  assign filt_nx  = run_done ? smp : filt_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode_q <= '0;
      run_q  <= '0;
      prev_q <= 1'b0;
      filt_q <= 1'b0;
    end else begin
      mode_q <= mode_sel;
      run_q  <= run_nx;
      prev_q <= prev_nx;
      filt_q <= filt_nx;
    end

  assign filt = filt_q;

  // R6
  filt_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q != $past(filt_q)) |-> $past(strobe_hit));
  // R4
  filt_takes_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q != $past(filt_q)) |-> (filt_q == $past(smp)));
  // R9
  mode_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (run_q == '0));
  // R5
  run_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_en && (run_q != '0) && (smp != prev_q)) |=> (run_q == RUN_W'(1)));
endmodule

// File: rtl/pin_cond_filter.sv
module pin_cond_filter
  import pcf_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STROBE_CNT  = 8,
  localparam int SEL_W = $clog2(STROBE_CNT)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pin_raw,
  input  logic [MODE_W-1:0]     mode_sel,
  input  logic [SEL_W-1:0]      strobe_sel,
  input  logic [STROBE_CNT-1:0] strobe_vec,
  input  logic                  invert,
  output logic                  pin_out
);
  logic pin_sync;
  logic pin_filt;
  logic level;

  pcf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d (pin_raw),
    .q (pin_sync)
  );

  pcf_agree #(.STROBE_CNT(STROBE_CNT)) u_agree (
    .clk (clk),
    .rst_n (rst_n),
    .smp (pin_sync),
    .mode_sel (mode_sel),
    .strobe_sel (strobe_sel),
    .strobe_vec (strobe_vec),
    .filt (pin_filt)
  );

  always_comb begin
    if (mode_sel == PCF_DIRECT)        level = pin_raw;
    else if (pcf_is_filter(mode_sel))  level = pin_filt;
    else                               level = pin_sync;
  end

  assign pin_out = level ^ invert;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    (!rst_n && (mode_sel != PCF_DIRECT)) |-> (pin_out == invert));
endmodule

// File: tb/pin_cond_filter_test.sv
module pin_cond_filter_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin_raw = 1'b0;
  logic [2:0] mode_sel = 3'd0;
  logic [2:0] strobe_sel = 3'd0;
  logic [7:0] strobe_vec = 8'hFF;
  logic       invert = 1'b0;
  logic       pin_out;

  int vectors = 0;
  int miscmp  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_cond_filter uut (
    .clk (clk), .rst_n (rst_n), .pin_raw (pin_raw), .mode_sel (mode_sel),
    .strobe_sel (strobe_sel), .strobe_vec (strobe_vec), .invert (invert),
    .pin_out (pin_out)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_bit(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscmp++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscmp++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [2:0] m, input logic [2:0] s,
                          input logic [7:0] v, input logic inv);
    @(negedge clk);
    rst_n = 1'b0; pin_raw = 1'b0;
    mode_sel = m; strobe_sel = s; strobe_vec = v; invert = inv;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
  endtask

  // drive a level and count edges until pin_out shows it (after invert)
  task automatic measure(input logic lvl, output int lat);
    pin_raw = lvl;
    lat = 0;
    #1;
    while ((pin_out !== (lvl ^ invert)) && lat < 20) begin
      tick();
      lat++;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0; mode_sel = 3'd0; invert = 1'b0; pin_raw = 1'b1;
    repeat (3) tick();
    check_bit("R1 out low in reset", pin_out, 1'b0);
    pin_raw = 1'b0;
    tick();
    rst_n = 1'b1;
  endtask

  task automatic t_sync();
    int lat;
    do_reset(3'd0, 3'd0, 8'hFF, 1'b0);
    measure(1'b1, lat); check_int("R2 sync rise latency", lat, 2);
    measure(1'b0, lat); check_int("R2 sync fall latency", lat, 2);
  endtask

  task automatic t_direct();
    int lat;
    do_reset(3'd1, 3'd0, 8'hFF, 1'b0);
    measure(1'b1, lat); check_int("R3 direct rise latency", lat, 0);
    pin_raw = 1'b0; #2;
    check_bit("R3 direct mid-cycle follow", pin_out, 1'b0);
    pin_raw = 1'b1; #1;
    check_bit("R3 direct mid-cycle follow 2", pin_out, 1'b1);
  endtask

  task automatic t_filters();
    int lat;
    for (int m = 2; m <= 5; m++) begin
      do_reset(3'(m), 3'd0, 8'hFF, 1'b0);
      measure(1'b1, lat); check_int($sformatf("R4 mode %0d rise", m), lat, m + 2);
      tick(); tick();
      measure(1'b0, lat); check_int($sformatf("R4 mode %0d fall", m), lat, m + 2);
    end
  endtask

  task automatic t_glitch();
    logic ok;
    logic seen;
    do_reset(3'd4, 3'd0, 8'hFF, 1'b0);
    pin_raw = 1'b1;
    repeat (3) tick();
    pin_raw = 1'b0;
    ok = 1'b1;
    for (int i = 0; i < 10; i++) begin
      tick();
      if (pin_out !== 1'b0) ok = 1'b0;
    end
    check_bit("R5 three-sample pulse rejected", ok, 1'b1);
    pin_raw = 1'b1;
    repeat (4) tick();
    pin_raw = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 10; i++) begin
      tick();
      if (pin_out === 1'b1) seen = 1'b1;
    end
    check_bit("R5 four-sample pulse accepted", seen, 1'b1);
    check_bit("R5 returns low after pulse", pin_out, 1'b0);
  endtask

  task automatic t_strobe();
    // mode 3, strobe index 5; bit 5 held low, the rest high
    do_reset(3'd3, 3'd5, 8'hDF, 1'b0);
    pin_raw = 1'b1;
    repeat (10) tick();
    check_bit("R6 unselected strobes ignored", pin_out, 1'b0);
    for (int k = 1; k <= 3; k++) begin
      strobe_vec = 8'hFF;
      tick();
      strobe_vec = 8'hDF;
      tick();
      check_bit($sformatf("R6 after strobe pulse %0d", k), pin_out, (k >= 3));
    end
  endtask

  task automatic t_invert();
    int lat;
    do_reset(3'd0, 3'd0, 8'hFF, 1'b1);
    check_bit("R7 sync inverted idle", pin_out, 1'b1);
    measure(1'b1, lat); check_int("R7 sync inverted latency", lat, 2);
    check_bit("R7 sync inverted level", pin_out, 1'b0);
    do_reset(3'd1, 3'd0, 8'hFF, 1'b1);
    pin_raw = 1'b1; #1;
    check_bit("R7 direct inverted", pin_out, 1'b0);
    do_reset(3'd3, 3'd0, 8'hFF, 1'b1);
    check_bit("R7 filter inverted idle", pin_out, 1'b1);
    measure(1'b1, lat); check_int("R7 filter inverted latency", lat, 5);
  endtask

  task automatic t_reserved();
    int lat;
    for (int m = 6; m <= 7; m++) begin
      do_reset(3'(m), 3'd0, 8'hFF, 1'b0);
      measure(1'b1, lat); check_int($sformatf("R8 mode %0d rise", m), lat, 2);
      measure(1'b0, lat); check_int($sformatf("R8 mode %0d fall", m), lat, 2);
    end
  endtask

  task automatic t_modechg();
    do_reset(3'd5, 3'd0, 8'hFF, 1'b0);
    pin_raw = 1'b1;
    repeat (5) tick();
    check_bit("R9 no output before run done", pin_out, 1'b0);
    mode_sel = 3'd4;
    repeat (4) tick();
    check_bit("R9 run restarted after mode change", pin_out, 1'b0);
    tick();
    check_bit("R9 full run after mode change", pin_out, 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    miscmp++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

  initial begin
    t_reset();
    t_sync();
    t_direct();
    t_filters();
    t_glitch();
    t_strobe();
    t_invert();
    t_reserved();
    t_modechg();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end
endmodule